// File: doc/BRIEF.md
# Translate-and-Test Byte String Engine

This block scans a string of bytes in memory and stops on the first byte whose translated value has a bit in common with a test mask. Each byte of the scanned string is used as an index into a 256-entry translation table. The table entry it selects is ANDed with an 8-bit mask, and the scan ends at the first nonzero result. On a stop, the overlapping bits replace the mask, a condition flag is set, and the string address is left pointing at the byte that caused the stop.

The engine is loaded from an even/odd register pair. The even register carries the mask and a source (table) address. The odd register carries a byte count and the address of the string. When the register field is zero, the table base is taken from the displacement alone and the mask is all ones. An odd register field, or an indirectly addressed instruction, is rejected with a trap vector and no memory access.

The count and the address are committed byte by byte. An interrupt request can therefore park the operation at a byte boundary, and it can later be restarted from the register values the engine reports.

Top module: `xlat_test_engine`

## Requirements
- R1: For each string byte B (read at the string address), the engine reads the table byte at table base + B and ANDs it with the mask. A zero result advances to the next byte: the count (bits 31:24 of the odd register) drops by one and the address (bits 23:0) rises by one.
- R2: On the first nonzero AND result the scan stops with cc4_o = 1. The odd register keeps the address and the count of the byte that hit, and the mask field (bits 31:24 of the even register) is replaced by the AND result.
- R3: When all C bytes test zero, the engine finishes with cc4_o = 0, the count is zero and the address has advanced by C.
- R4: A count of zero at start finishes two cycles after start_i with done_o = 1 and cc4_o = 0, and the engine issues no memory read.
- R5: A direct instruction with an odd register field raises trap_o one cycle after start_i with trap_vec_o = 8'h4D. Both register outputs are returned unchanged and no memory read is issued.
- R6: An indirectly addressed instruction raises trap_o with trap_vec_o = 8'h40 one cycle after start_i, whatever the register field is. The registers are returned unchanged and no read is issued.
- R7: With register field 0, the mask is 8'hFF, the table base equals the displacement, and reg_r_o returns the even register input unchanged even on a hit.
- R8: With a nonzero even field, the table base is the displacement plus bits 23:0 of the even register, taken modulo 2^24.
- R9: If intr_i is high at a byte boundary with the count nonzero, the engine stops with done_o and paused_o both high. The odd register output then holds the count and address of the next unprocessed byte, and restarting from the reported registers gives the same final result as an uninterrupted run.
- R10: mem_req_o stays high with a stable mem_addr_o until mem_valid_i answers. The engine only reads memory.
- R11: done_o and trap_o are single-cycle pulses and never coincide, and busy_o is high from the cycle after start until the cycle of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (sampled while idle) |
| rfield_i | input | 4 | Register field of the instruction |
| indirect_i | input | 1 | Instruction is indirectly addressed |
| disp_i | input | 24 | Displacement of the instruction |
| reg_r_i | input | 32 | Even register: mask [31:24], source address [23:0] |
| reg_r1_i | input | 32 | Odd register: count [31:24], string address [23:0] |
| intr_i | input | 1 | Interrupt request, honoured between bytes |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 24 | Byte read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 8 | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| paused_o | output | 1 | Completion was an interrupt park |
| trap_o | output | 1 | Trap pulse |
| trap_vec_o | output | 8 | Trap vector |
| cc4_o | output | 1 | Hit flag |
| reg_r_o | output | 32 | Final even register value |
| reg_r1_o | output | 32 | Final odd register value |

## Verification
Assertions check several properties on every cycle: the request/valid hold rule, the pulse shape and exclusivity of done and trap, the trap vectors and their one-cycle timing, the zero-count completion timing, that no request appears while idle, and that a hit never reports a zero count. Only the bench scenarios can show that the right table entry was chosen. They also show the final mask, count and address for hit, miss, zero-field, wrap-around and parked runs, and the number of reads each run made. Whether a parked run resumes to the same answer can also be seen only from a scenario.

// File: rtl/xlat_test_pkg.sv
package xlat_test_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RDSTR = 2'd2,
        ST_RDTBL = 2'd3
    } scan_state_e;

    localparam logic [7:0] VEC_NONEXIST  = 8'h40;
    localparam logic [7:0] VEC_INSTR_EXC = 8'h4D;

endpackage

// File: rtl/xlat_test_addr.sv
module xlat_test_addr #(
    parameter int W = 24
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    // modulo-2^W byte address sum
    always_comb begin
        sum_o = a_i + b_i;
    end
endmodule

// File: rtl/xlat_test_mask.sv
module xlat_test_mask #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] entry_i,
    input  logic [BYTE_W-1:0] mask_i,
    output logic              hit_o,
    output logic [BYTE_W-1:0] overlap_o
);
    always_comb begin
        overlap_o = entry_i & mask_i;
        hit_o     = |overlap_o;
    end
endmodule

// File: rtl/xlat_test_decode.sv
module xlat_test_decode
    import xlat_test_pkg::*;
#(
    parameter int RF_W   = 4,
    parameter int ADDR_W = 24,
    parameter int BYTE_W = 8
) (
    input  logic [RF_W-1:0]   rfield_i,
    input  logic              indirect_i,
    input  logic [ADDR_W-1:0] disp_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [BYTE_W-1:0] mask_i,
    output logic              trap_o,
    output logic [7:0]        vec_o,
    output logic              zero_o,
    output logic [BYTE_W-1:0] mask_o,
    output logic [ADDR_W-1:0] base_o
);
    logic [ADDR_W-1:0] src_sel;

    always_comb begin
        zero_o = (rfield_i == '0);
        // indirect addressing is caught at decode, ahead of the parity check
        if (indirect_i) begin
            trap_o = 1'b1;
            vec_o  = VEC_NONEXIST;
        end else if (rfield_i[0]) begin
            trap_o = 1'b1;
            vec_o  = VEC_INSTR_EXC;
        end else begin
            trap_o = 1'b0;
            vec_o  = 8'h00;
        end
        mask_o  = zero_o ? {BYTE_W{1'b1}} : mask_i;
        src_sel = zero_o ? '0 : src_i;
    end

    xlat_test_addr #(.W(ADDR_W)) u_base_add (
        .a_i  (disp_i),
        .b_i  (src_sel),
        .sum_o(base_o)
    );
endmodule

// File: rtl/xlat_test_engine.sv
module xlat_test_engine
    import xlat_test_pkg::*;
#(
    parameter int RF_W   = 4,
    parameter int ADDR_W = 24,
    parameter int BYTE_W = 8,
    parameter int REG_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [RF_W-1:0]   rfield_i,
    input  logic              indirect_i,
    input  logic [ADDR_W-1:0] disp_i,
    input  logic [REG_W-1:0]  reg_r_i,
    input  logic [REG_W-1:0]  reg_r1_i,
    input  logic              intr_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [BYTE_W-1:0] mem_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              paused_o,
    output logic              trap_o,
    output logic [7:0]        trap_vec_o,
    output logic              cc4_o,
    output logic [REG_W-1:0]  reg_r_o,
    output logic [REG_W-1:0]  reg_r1_o
);
    localparam int CNT_W = REG_W - ADDR_W;

    typedef struct packed {
        scan_state_e       st;
        logic [REG_W-1:0]  r;
        logic [REG_W-1:0]  r1;
        logic [BYTE_W-1:0] mask;
        logic [ADDR_W-1:0] base;
        logic [BYTE_W-1:0] sbyte;
        logic              zero;
        logic              done;
        logic              paused;
        logic              trap;
        logic [7:0]        vec;
        logic              cc4;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic              dec_trap, dec_zero, hit;
    logic [7:0]        dec_vec;
    logic [BYTE_W-1:0] dec_mask, overlap;
    logic [ADDR_W-1:0] dec_base, tbl_addr;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] saddr_q;

    assign cnt_q   = ctx_q.r1[REG_W-1 -: CNT_W];
    assign saddr_q = ctx_q.r1[ADDR_W-1:0];

    xlat_test_decode #(
        .RF_W  (RF_W),
        .ADDR_W(ADDR_W),
        .BYTE_W(BYTE_W)
    ) u_decode (
        .rfield_i  (rfield_i),
        .indirect_i(indirect_i),
        .disp_i    (disp_i),
        .src_i     (reg_r_i[ADDR_W-1:0]),
        .mask_i    (reg_r_i[REG_W-1 -: BYTE_W]),
        .trap_o    (dec_trap),
        .vec_o     (dec_vec),
        .zero_o    (dec_zero),
        .mask_o    (dec_mask),
        .base_o    (dec_base)
    );

    xlat_test_addr #(.W(ADDR_W)) u_tbl_add (
        .a_i  (ctx_q.base),
        .b_i  (ADDR_W'(ctx_q.sbyte)),
        .sum_o(tbl_addr)
    );

    xlat_test_mask #(.BYTE_W(BYTE_W)) u_mask (
        .entry_i  (mem_data_i),
        .mask_i   (ctx_q.mask),
        .hit_o    (hit),
        .overlap_o(overlap)
    );

    always_comb begin
        ctx_d        = ctx_q;
        ctx_d.done   = 1'b0;
        ctx_d.paused = 1'b0;
        ctx_d.trap   = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctx_d.r    = reg_r_i;
                    ctx_d.r1   = reg_r1_i;
                    ctx_d.cc4  = 1'b0;
                    ctx_d.vec  = dec_vec;
                    ctx_d.mask = dec_mask;
                    ctx_d.base = dec_base;
                    ctx_d.zero = dec_zero;
                    if (dec_trap) begin
                        ctx_d.trap = 1'b1;
                    end else begin
                        ctx_d.st = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                if (cnt_q == '0) begin
                    ctx_d.done = 1'b1;
                    ctx_d.st   = ST_IDLE;
                end else if (intr_i) begin
                    ctx_d.done   = 1'b1;
                    ctx_d.paused = 1'b1;
                    ctx_d.st     = ST_IDLE;
                end else begin
                    ctx_d.st = ST_RDSTR;
                end
            end
            ST_RDSTR: begin
                if (mem_valid_i) begin
                    ctx_d.sbyte = mem_data_i;
                    ctx_d.st    = ST_RDTBL;
                end
            end
            ST_RDTBL: begin
                if (mem_valid_i) begin
                    if (hit) begin
                        ctx_d.cc4  = 1'b1;
                        ctx_d.done = 1'b1;
                        ctx_d.st   = ST_IDLE;
                        if (!ctx_q.zero) begin
                            ctx_d.r[REG_W-1 -: BYTE_W] = overlap;
                        end
                    end else begin
                        ctx_d.r1 = {cnt_q - CNT_W'(1), saddr_q + ADDR_W'(1)};
                        ctx_d.st = ST_CHECK;
                    end
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign mem_req_o  = (ctx_q.st == ST_RDSTR) || (ctx_q.st == ST_RDTBL);
    assign mem_addr_o = (ctx_q.st == ST_RDTBL) ? tbl_addr : saddr_q;
    assign busy_o     = (ctx_q.st != ST_IDLE);
    assign done_o     = ctx_q.done;
    assign paused_o   = ctx_q.paused;
    assign trap_o     = ctx_q.trap;
    assign trap_vec_o = ctx_q.vec;
    assign cc4_o      = ctx_q.cc4;
    assign reg_r_o    = ctx_q.r;
    assign reg_r1_o   = ctx_q.r1;

    // R10: an unanswered request holds its address
    p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));

    // R4: no read while idle
    p_idle_no_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !mem_req_o);

    // R11: pulse shape and exclusivity
    p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    p_done_trap_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && trap_o));

    // R5 / R6: trap vectors one cycle after start
    p_odd_trap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && !busy_o && !indirect_i && rfield_i[0]
        |=> trap_o && trap_vec_o == 8'h4D);
    p_indirect_trap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && !busy_o && indirect_i |=> trap_o && trap_vec_o == 8'h40);
    p_trap_regs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> reg_r_o == $past(reg_r_i) && reg_r1_o == $past(reg_r1_i));

    // R4: zero count completes two cycles after start without a hit
    p_zero_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && !busy_o && !indirect_i && !rfield_i[0]
        && reg_r1_i[REG_W-1 -: CNT_W] == '0
        |=> ##1 (done_o && !cc4_o));

    // R2: a hit always leaves the hitting byte counted
    p_hit_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && cc4_o |-> reg_r1_o[REG_W-1 -: CNT_W] != '0);
endmodule

// File: tb/xlat_test_engine_bench.sv
module xlat_test_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  rfield = '0;
    logic        indirect = 1'b0;
    logic [23:0] disp = '0;
    logic [31:0] reg_r = '0, reg_r1 = '0;
    logic        intr = 1'b0;
    logic        mem_req, mem_valid = 1'b0;
    logic [23:0] mem_addr;
    logic [7:0]  mem_data = '0;
    logic        busy, done, paused, trap, cc4;
    logic [7:0]  trap_vec;
    logic [31:0] reg_r_out, reg_r1_out;

    logic [7:0]  mem [0:4095];
    int          rd_cnt = 0;
    int          cyc = 0;
    bit          wd_expired = 1'b0;
    int          n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    xlat_test_engine u_xlat_test_engine (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rfield_i(rfield),
        .indirect_i(indirect), .disp_i(disp), .reg_r_i(reg_r), .reg_r1_i(reg_r1),
        .intr_i(intr), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_valid_i(mem_valid), .mem_data_i(mem_data), .busy_o(busy),
        .done_o(done), .paused_o(paused), .trap_o(trap), .trap_vec_o(trap_vec),
        .cc4_o(cc4), .reg_r_o(reg_r_out), .reg_r1_o(reg_r1_out)
    );

    // memory: one wait cycle, then a one-cycle valid
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
        end else if (mem_req && !mem_valid) begin
            mem_valid <= 1'b1;
            mem_data  <= mem[mem_addr[11:0]];
            rd_cnt    <= rd_cnt + 1;
        end else begin
            mem_valid <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) wd_expired <= 1'b1;
    end

    typedef struct packed {
        logic [3:0]  rf;
        logic        ind;
        logic [23:0] dsp;
        logic [31:0] r;
        logic [31:0] r1;
        logic        x_trap;
        logic [7:0]  x_vec;
        logic        x_cc4;
        logic [31:0] x_r;
        logic [31:0] x_r1;
        logic [7:0]  x_reads;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b0, 24'h000800, 32'h04000000, 32'h05000100, 1'b0, 8'h00, 1'b1, 32'h04000000, 32'h03000102, 8'd6},
        '{4'd2, 1'b0, 24'h000800, 32'h01000000, 32'h05000100, 1'b0, 8'h00, 1'b1, 32'h01000000, 32'h02000103, 8'd8},
        '{4'd2, 1'b0, 24'h000800, 32'h08000000, 32'h05000100, 1'b0, 8'h00, 1'b0, 32'h08000000, 32'h00000105, 8'd10},
        '{4'd4, 1'b0, 24'h000700, 32'hF0000100, 32'h03000200, 1'b0, 8'h00, 1'b1, 32'h10000100, 32'h03000200, 8'd2},
        '{4'd0, 1'b0, 24'h000A00, 32'h12345678, 32'h05000100, 1'b0, 8'h00, 1'b1, 32'h12345678, 32'h02000103, 8'd8},
        '{4'd3, 1'b0, 24'h000800, 32'h04000000, 32'h05000100, 1'b1, 8'h4D, 1'b0, 32'h04000000, 32'h05000100, 8'd0},
        '{4'd3, 1'b1, 24'h000800, 32'h04000000, 32'h05000100, 1'b1, 8'h40, 1'b0, 32'h04000000, 32'h05000100, 8'd0},
        '{4'd2, 1'b1, 24'h000800, 32'h04000000, 32'h05000100, 1'b1, 8'h40, 1'b0, 32'h04000000, 32'h05000100, 8'd0},
        '{4'd2, 1'b0, 24'h000800, 32'h04000000, 32'h00000100, 1'b0, 8'h00, 1'b0, 32'h04000000, 32'h00000100, 8'd0},
        '{4'd2, 1'b0, 24'h000900, 32'h04FFFF00, 32'h05000100, 1'b0, 8'h00, 1'b1, 32'h04FFFF00, 32'h03000102, 8'd6}
    };
    localparam string VTAG [NV] = '{"R1 R2", "R1 R2", "R3", "R2 R8", "R7",
                                     "R5", "R6", "R6", "R4", "R8"};

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // launch one operation; return on the done or trap pulse (sampled at negedge)
    task automatic launch(input logic [3:0] rf, input logic ind, input logic [23:0] dsp,
                          input logic [31:0] r, input logic [31:0] r1, output int reads);
        int base;
        @(negedge clk);
        rfield = rf; indirect = ind; disp = dsp; reg_r = r; reg_r1 = r1;
        start = 1'b1;
        base = rd_cnt;
        @(negedge clk);
        start = 1'b0;
        while (!(done || trap) && !wd_expired) @(negedge clk);
        reads = rd_cnt - base;
    endtask

    initial begin
        int reads;
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        mem[12'h100] = 8'h20; mem[12'h101] = 8'h21; mem[12'h102] = 8'h41;
        mem[12'h103] = 8'h5A; mem[12'h104] = 8'h00;
        mem[12'h200] = 8'h30; mem[12'h201] = 8'h31; mem[12'h202] = 8'h32;
        mem[12'h841] = 8'h06; mem[12'h85A] = 8'h81; mem[12'h830] = 8'h10;
        mem[12'hA5A] = 8'h20;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R11)
        chk("R11 reset busy", 64'(busy), 64'd0);
        chk("R11 reset pulses", 64'({done, trap}), 64'd0);
        chk("R10 reset req", 64'(mem_req), 64'd0);

        for (int v = 0; v < NV; v++) begin
            launch(VECS[v].rf, VECS[v].ind, VECS[v].dsp, VECS[v].r, VECS[v].r1, reads);
            chk($sformatf("%s vec%0d trap", VTAG[v], v), 64'(trap), 64'(VECS[v].x_trap));
            if (VECS[v].x_trap) begin
                chk($sformatf("%s vec%0d vector", VTAG[v], v), 64'(trap_vec), 64'(VECS[v].x_vec));
            end else begin
                chk($sformatf("%s vec%0d cc4", VTAG[v], v), 64'(cc4), 64'(VECS[v].x_cc4));
                chk($sformatf("%s vec%0d paused", VTAG[v], v), 64'(paused), 64'd0);
            end
            chk($sformatf("%s vec%0d reg_r", VTAG[v], v), 64'(reg_r_out), 64'(VECS[v].x_r));
            chk($sformatf("%s vec%0d reg_r1", VTAG[v], v), 64'(reg_r1_out), 64'(VECS[v].x_r1));
            chk($sformatf("%s R10 vec%0d reads", VTAG[v], v), 64'(reads), 64'(VECS[v].x_reads));
            @(negedge clk);
            chk($sformatf("R11 vec%0d pulse ends", v), 64'({done, trap, busy}), 64'd0);
        end

        // R9: park after two bytes, then resume from the reported registers
        fork
            begin
                int b0;
                b0 = rd_cnt;
                @(negedge clk);
                while (rd_cnt - b0 < 4 && !wd_expired) @(negedge clk);
                intr = 1'b1;
            end
            launch(4'd2, 1'b0, 24'h000800, 32'h08000000, 32'h05000100, reads);
        join
        intr = 1'b0;
        chk("R9 parked done", 64'(done), 64'd1);
        chk("R9 parked flag", 64'(paused), 64'd1);
        chk("R9 parked reg_r1", 64'(reg_r1_out), 64'h03000102);
        chk("R9 parked reads", 64'(reads), 64'd4);
        launch(4'd2, 1'b0, 24'h000800, reg_r_out, reg_r1_out, reads);
        chk("R9 resumed cc4", 64'(cc4), 64'd0);
        chk("R9 resumed paused", 64'(paused), 64'd0);
        chk("R9 resumed reg_r1", 64'(reg_r1_out), 64'h00000105);
        chk("R9 resumed reads", 64'(reads), 64'd6);

        if (wd_expired) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual expired expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule